// File: doc/BRIEF.md
# FIR Decimator With Shared Coefficient RAM

This block is one FIR decimation stage for an audio capture path. It reads its taps from a coefficient memory that several cascaded stages share. Software loads that memory through a two-register write port. One write sets a load pointer. Each following data write stores one signed 24-bit coefficient and moves the pointer on by one, so a long run of taps for several stages goes in without a new address each time.

The stage is given a base offset into the memory and a tap count. It keeps a history of the 24-bit input samples. On every D-th accepted sample it runs a sequential multiply-accumulate, one tap per clock, over the newest samples against the coefficients starting at the base offset. It scales the sum down by 2^22, so the coefficient 0x400000 is unity gain. It then rounds, saturates and presents one 24-bit result.

The control word uses these fields: bit 31 enables the stage, bits [17:16] select rounding, bits [15:12] give the decimation factor and bits [8:0] give the tap count. The bits in between are ignored.

Top module: `fir_decim_stage`

## Requirements
- R1: After reset, out_valid is low, out_data is zero and the coefficient load pointer is zero.
- R2: A write with cfg_wr_sel=0 sets the load pointer to cfg_wr_data[8:0]. A write with cfg_wr_sel=1 stores cfg_wr_data[23:0] as a signed coefficient at the pointer and then adds one to the pointer. Bits [31:24] of a data write are ignored. A store at a pointer of 336 or more is dropped, and a coefficient address of 336 or more reads as zero.
- R3: Each result equals floor-or-round of (sum over k=0..T-1 of C[B+k]·x[n-k]) / 2^22. Here T=stage_ctrl[8:0], B=stage_base, and x[n] is the newest accepted sample.
- R4: With D=stage_ctrl[15:12], a result is produced on every D-th sample accepted since enable, and D=0 acts as 1. out_valid is a one-cycle pulse that comes at most T+2 cycles after that sample. No result-producing sample may arrive while the previous result is still being computed, and a sample that arrives then is lost.
- R5: Rounding mode stage_ctrl[17:16]=1 adds 2^21 to the sum before the arithmetic right shift by 22. Modes 0, 2 and 3 take the floor.
- R6: A result above 0x7FFFFF is output as 0x7FFFFF, and a result below -0x800000 is output as 0x800000.
- R7: While stage_ctrl[31] is low, in_valid is ignored and out_valid stays low. The sample history and the decimation phase are cleared, so after re-enabling, every sample from before counts as zero.
- R8: A tap count of zero yields a result of zero on each decimation boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | 0 selects the load pointer, 1 the coefficient data |
| cfg_wr_data | input | 32 | Write data |
| stage_ctrl | input | 32 | Stage control word (enable, rounding, decimation, tap count) |
| stage_base | input | 9 | First coefficient address of this stage |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Result strobe, one cycle |
| out_data | output | 24 | Signed decimated result |

## Verification
A single unity tap shows that the datapath and the scaling are right before any arithmetic mixes values. A five-tap set with mixed signs at a non-zero base offset, driven with alternating positive and negative samples, tells apart errors in tap order, in base offset, in sign extension, and in zero-filling the history on start-up. Half-valued coefficients against odd inputs of both signs separate the rounding modes. Full-scale inputs drive the sum past both limits to test saturation. Runs that change the decimation factor, disable the stage while samples keep arriving, load coefficients at the top of the memory and rewrite a single coefficient in place cover the phase counting, the clearing of history on disable, the memory boundary and the pointer handling.

// File: rtl/fir_dec_pkg.sv
`timescale 1ns/1ps
package fir_dec_pkg;
  localparam int SAMPLE_W   = 24;
  localparam int COEF_W     = 24;
  localparam int TAPS_W     = 9;
  localparam int DEC_W      = 4;
  localparam int MODE_W     = 2;
  localparam int BUS_W      = 32;
  localparam int PROD_W     = SAMPLE_W + COEF_W;

  // control word field positions (decoded by the top)
  localparam int F_TAPS_LSB = 0;
  localparam int F_DEC_LSB  = 12;
  localparam int F_MODE_LSB = 16;
  localparam int F_EN_BIT   = 31;

  typedef enum logic [MODE_W-1:0] {
    RND_TRUNC   = 2'd0,
    RND_HALF_UP = 2'd1,
    RND_RSV2    = 2'd2,
    RND_RSV3    = 2'd3
  } rnd_mode_e;

  typedef enum logic [1:0] {
    MAC_IDLE = 2'd0,
    MAC_RUN  = 2'd1,
    MAC_FIN  = 2'd2
  } mac_state_e;

  typedef struct packed {
    logic              en;
    rnd_mode_e         mode;
    logic [DEC_W-1:0]  dec;
    logic [TAPS_W-1:0] taps;
  } stage_cfg_t;
endpackage

// File: rtl/fir_coef_store.sv
`timescale 1ns/1ps
module fir_coef_store
  import fir_dec_pkg::*;
#(
  parameter int DEPTH = 336,
  parameter int AW    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [AW:0]       rd_addr,
  output logic [COEF_W-1:0] rd_data
);
  logic [COEF_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     ptr_q, ptr_d;
  logic              store;
  logic              unused_hi;

  assign unused_hi = ^wr_data[BUS_W-1:COEF_W];

  // next pointer and store decision
  always_comb begin
    ptr_d = ptr_q;
    store = 1'b0;
    if (wr_en) begin
      if (!wr_sel) begin
        ptr_d = wr_data[AW-1:0];
      end else begin
        ptr_d = ptr_q + AW'(1);
        store = (int'(ptr_q) < DEPTH);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (store) mem_q[ptr_q] <= wr_data[COEF_W-1:0];
  end

  assign rd_data = (int'(rd_addr) < DEPTH) ? mem_q[rd_addr[AW-1:0]] : '0;

  // R2: the pointer moves only on a register write
  p_ptr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr_q));
endmodule

// File: rtl/fir_hist_ring.sv
`timescale 1ns/1ps
module fir_hist_ring
  import fir_dec_pkg::*;
#(
  parameter int DEPTH = 128,   // power of two
  parameter int AW    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                push,
  input  logic [SAMPLE_W-1:0] push_data,
  input  logic                snap,
  input  logic [TAPS_W-1:0]   age,
  output logic [SAMPLE_W-1:0] rd_data
);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [SAMPLE_W-1:0] ring_q [DEPTH];
  logic [AW-1:0]       wptr_q, wptr_d, anchor_q, anchor_d;
  logic [AW:0]         fill_q, fill_d, afill_q, afill_d;
  logic [AW-1:0]       rd_idx;

  always_comb begin
    wptr_d   = wptr_q;
    fill_d   = fill_q;
    anchor_d = anchor_q;
    afill_d  = afill_q;
    if (clear) begin
      wptr_d  = '0;
      fill_d  = '0;
      afill_d = '0;
    end else if (push) begin
      wptr_d = wptr_q + AW'(1);
      if (fill_q != FULL) fill_d = fill_q + (AW+1)'(1);
      if (snap) begin
        anchor_d = wptr_q;
        afill_d  = (fill_q == FULL) ? FULL : fill_q + (AW+1)'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      fill_q   <= '0;
      anchor_q <= '0;
      afill_q  <= '0;
    end else begin
      wptr_q   <= wptr_d;
      fill_q   <= fill_d;
      anchor_q <= anchor_d;
      afill_q  <= afill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) ring_q[wptr_q] <= push_data;
  end

  assign rd_idx  = anchor_q - age[AW-1:0];
  assign rd_data = (int'(age) < int'(afill_q)) ? ring_q[rd_idx] : '0;

  // R7: the history count never exceeds the ring
  p_fill_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL);
  // R7: clearing empties the history on the next cycle
  p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fill_q == '0) && (afill_q == '0));
endmodule

// File: rtl/fir_mac_core.sv
`timescale 1ns/1ps
module fir_mac_core
  import fir_dec_pkg::*;
#(
  parameter int ACC_W = 57,
  parameter int SHIFT = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  stage_cfg_t          cfg,
  input  logic                in_valid,
  input  logic [COEF_W-1:0]   coef_in,
  input  logic [SAMPLE_W-1:0] samp_in,
  output logic                start,
  output logic [TAPS_W-1:0]   tap_k,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data
);
  localparam logic signed [ACC_W-1:0] HALF_LSB =
    {{(ACC_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  mac_state_e               st_q, st_d;
  logic [DEC_W-1:0]         phase_q, phase_d, last_phase;
  logic [TAPS_W-1:0]        k_q, k_d;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic                     ov_q, ov_d;
  logic [SAMPLE_W-1:0]      od_q, od_d;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, rnd, shr;

  // decimation phase
  assign last_phase = (cfg.dec == '0) ? '0 : cfg.dec - DEC_W'(1);
  assign start      = cfg.en && in_valid && (phase_q == last_phase);

  always_comb begin
    phase_d = phase_q;
    if (!cfg.en)       phase_d = '0;
    else if (start)    phase_d = '0;
    else if (in_valid) phase_d = phase_q + DEC_W'(1);
  end

  // datapath
  assign prod     = $signed(coef_in) * $signed(samp_in);
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign rnd      = (cfg.mode == RND_HALF_UP) ? acc_q + HALF_LSB : acc_q;
  assign shr      = rnd >>> SHIFT;

  // sequencer next state
  always_comb begin
    st_d  = st_q;
    k_d   = k_q;
    acc_d = acc_q;
    ov_d  = 1'b0;
    od_d  = od_q;
    if (!cfg.en) begin
      st_d = MAC_IDLE;
    end else begin
      unique case (st_q)
        MAC_IDLE: begin
          if (start) begin
            acc_d = '0;
            k_d   = '0;
            st_d  = (cfg.taps == '0) ? MAC_FIN : MAC_RUN;
          end
        end
        MAC_RUN: begin
          acc_d = acc_q + prod_ext;
          if (k_q + TAPS_W'(1) == cfg.taps) st_d = MAC_FIN;
          else                              k_d  = k_q + TAPS_W'(1);
        end
        MAC_FIN: begin
          ov_d = 1'b1;
          if (shr > SAT_HI)      od_d = SAT_HI[SAMPLE_W-1:0];
          else if (shr < SAT_LO) od_d = SAT_LO[SAMPLE_W-1:0];
          else                   od_d = shr[SAMPLE_W-1:0];
          st_d = MAC_IDLE;
        end
        default: st_d = MAC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= MAC_IDLE;
      phase_q <= '0;
      k_q     <= '0;
      acc_q   <= '0;
      ov_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      st_q    <= st_d;
      phase_q <= phase_d;
      k_q     <= k_d;
      acc_q   <= acc_d;
      ov_q    <= ov_d;
      od_q    <= od_d;
    end
  end

  assign tap_k     = k_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;

  // R4: a result strobe lasts one cycle
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R4: a result-producing sample never lands on a busy sequencer
  p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == MAC_IDLE));
  // R3: the tap index stays inside the programmed tap count
  p_tap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == MAC_RUN) |-> (k_q < cfg.taps));
  // R7: a disabled stage emits nothing
  p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> !out_valid);
endmodule

// File: rtl/fir_decim_stage.sv
`timescale 1ns/1ps
module fir_decim_stage
  import fir_dec_pkg::*;
#(
  parameter int COEF_DEPTH = 336,
  parameter int HIST_DEPTH = 128,
  parameter int OUT_SHIFT  = 22
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr_en,
  input  logic                          cfg_wr_sel,
  input  logic [31:0]                   cfg_wr_data,
  input  logic [31:0]                   stage_ctrl,
  input  logic [$clog2(COEF_DEPTH)-1:0] stage_base,
  input  logic                          in_valid,
  input  logic [23:0]                   in_data,
  output logic                          out_valid,
  output logic [23:0]                   out_data
);
  localparam int CA_W  = $clog2(COEF_DEPTH);
  localparam int HA_W  = $clog2(HIST_DEPTH);
  localparam int ACC_W = SAMPLE_W + COEF_W + TAPS_W;

  stage_cfg_t          cfg;
  logic                start;
  logic [TAPS_W-1:0]   tap_k;
  logic [CA_W:0]       coef_addr;
  logic [COEF_W-1:0]   coef;
  logic [SAMPLE_W-1:0] samp;
  logic                unused_ctrl;

  assign cfg.en   = stage_ctrl[F_EN_BIT];
  assign cfg.mode = rnd_mode_e'(stage_ctrl[F_MODE_LSB +: MODE_W]);
  assign cfg.dec  = stage_ctrl[F_DEC_LSB +: DEC_W];
  assign cfg.taps = stage_ctrl[F_TAPS_LSB +: TAPS_W];
  assign unused_ctrl = ^{stage_ctrl[30:18], stage_ctrl[11:9]};

  assign coef_addr = (CA_W+1)'(stage_base) + (CA_W+1)'(tap_k);

  fir_coef_store #(.DEPTH(COEF_DEPTH), .AW(CA_W)) u_coef (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (cfg_wr_data),
    .rd_addr (coef_addr),
    .rd_data (coef)
  );

  fir_hist_ring #(.DEPTH(HIST_DEPTH), .AW(HA_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!cfg.en),
    .push      (cfg.en && in_valid),
    .push_data (in_data),
    .snap      (start),
    .age       (tap_k),
    .rd_data   (samp)
  );

  fir_mac_core #(.ACC_W(ACC_W), .SHIFT(OUT_SHIFT)) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .in_valid  (in_valid),
    .coef_in   (coef),
    .samp_in   (samp),
    .start     (start),
    .tap_k     (tap_k),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: tb/fir_decim_stage_test.sv
`timescale 1ns/1ps
module fir_decim_stage_test;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic        cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic [31:0] stage_ctrl;
  logic [8:0]  stage_base;
  logic        in_valid;
  logic [23:0] in_data;
  logic        out_valid;
  logic [23:0] out_data;

  int checks;
  int errors;
  bit finished;

  longint coef_m [336];
  longint hist_m [$];
  int     mon_q  [$];
  int     ptr_m;
  int     phase_m;
  bit     cur_en;
  int     cur_mode, cur_dec, cur_taps, cur_base;

  fir_decim_stage uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .stage_ctrl(stage_ctrl), .stage_base(stage_base),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  always @(negedge clk) begin
    if (out_valid) mon_q.push_back(int'(out_data));
  end

  function automatic longint sx(input int v);
    logic signed [23:0] b;
    b = v[23:0];
    return longint'(b);
  endfunction

  function automatic int model_out();
    longint acc = 0;
    longint r;
    for (int k = 0; k < cur_taps; k++) begin
      longint s = (k < hist_m.size()) ? hist_m[k] : 0;
      longint c = (cur_base + k < 336) ? coef_m[cur_base + k] : 0;
      acc += c * s;
    end
    if (cur_mode == 1) acc += longint'(1) <<< 21;
    r = acc >>> 22;
    if (r > 64'sd8388607) r = 64'sd8388607;
    if (r < -64'sd8388608) r = -64'sd8388608;
    return int'(r[23:0]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic wr_addr(input int a);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 1'b0; cfg_wr_data = 32'(a);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    ptr_m = a & 9'h1FF;
  endtask

  task automatic wr_coef(input int v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = 1'b1;
    cfg_wr_data = {8'hA5, v[23:0]};      // R2: top byte must be ignored
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (ptr_m < 336) coef_m[ptr_m] = sx(v);
    ptr_m = (ptr_m + 1) & 9'h1FF;
  endtask

  task automatic set_cfg(input bit en, input int mode, input int dec, input int taps, input int base);
    @(negedge clk);
    stage_ctrl = 32'h0;
    stage_ctrl[31]    = en;
    stage_ctrl[17:16] = mode[1:0];
    stage_ctrl[15:12] = dec[3:0];
    stage_ctrl[8:0]   = taps[8:0];
    stage_ctrl[30:18] = 13'h1ABC;          // unused bits, ignored
    stage_base = base[8:0];
    cur_en = en; cur_mode = mode; cur_dec = dec; cur_taps = taps; cur_base = base;
    if (!en) begin
      hist_m.delete();
      phase_m = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic restart(input int mode, input int dec, input int taps, input int base);
    set_cfg(1'b0, mode, dec, taps, base);
    set_cfg(1'b1, mode, dec, taps, base);
  endtask

  task automatic push(input int x, input string req);
    int d;
    bit due;
    @(negedge clk);
    in_valid = 1'b1; in_data = x[23:0];
    @(negedge clk);
    in_valid = 1'b0;
    due = 1'b0;
    if (cur_en) begin
      hist_m.push_front(sx(x));
      if (hist_m.size() > 128) void'(hist_m.pop_back());
      d = (cur_dec == 0) ? 1 : cur_dec;
      phase_m++;
      if (phase_m == d) begin
        phase_m = 0;
        due = 1'b1;
      end
    end
    if (due) begin
      int exp = model_out();
      repeat (cur_taps + 4) @(negedge clk);
      if (mon_q.size() == 1) check(mon_q[0] == exp, req, mon_q[0], exp);
      else check(1'b0, {req, " result count"}, mon_q.size(), 1);
    end else begin
      repeat (3) @(negedge clk);
      check(mon_q.size() == 0, {req, " no result"}, mon_q.size(), 0);
    end
    mon_q.delete();
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_data == 24'h0, "R1 out_data", int'(out_data), 0);
  endtask

  task automatic t_identity();
    // R1: no address write first, pointer starts at zero
    wr_coef(32'h400000);
    restart(0, 1, 1, 0);
    push(100, "R3 unity");
    push(-5, "R3 unity negative");
    push(32'h7FFFFF, "R3 unity full scale");
  endtask

  task automatic t_fir_offset();
    wr_addr(40);
    wr_coef(32'h400000);
    wr_coef(32'hE00000);
    wr_coef(32'h100000);
    wr_coef(32'h080000);
    wr_coef(32'h020000);
    restart(0, 1, 5, 40);
    push(1000, "R3 fill");
    push(-2000, "R3 fill");
    push(3000, "R3 fill");
    push(-4000, "R3 fill");
    push(5000, "R3 five taps");
    push(-6000, "R3 five taps");
    push(7000, "R3 five taps");
    wr_addr(42);                           // R2: rewrite one tap in place
    wr_coef(32'h000000);
    push(-8000, "R2 pointer reload");
    push(9000, "R2 pointer reload");
  endtask

  task automatic t_decim();
    restart(0, 3, 5, 40);
    for (int i = 0; i < 9; i++) push((i * 1234) - 4000, "R4 decimate by 3");
    restart(0, 0, 5, 40);
    push(777, "R4 factor zero as one");
    push(-888, "R4 factor zero as one");
  endtask

  task automatic t_round();
    wr_addr(100);
    wr_coef(32'h200000);
    for (int m = 0; m < 4; m++) begin
      restart(m, 1, 1, 100);
      push(3, "R5 round positive");
      push(-3, "R5 round negative");
    end
  endtask

  task automatic t_sat();
    wr_addr(110);
    wr_coef(32'h7FFFFF);
    wr_coef(32'h7FFFFF);
    restart(1, 1, 2, 110);
    push(32'h7FFFFF, "R6 high limit");
    push(32'h7FFFFF, "R6 high limit");
    push(32'h800000, "R6 mid");
    push(32'h800000, "R6 low limit");
  endtask

  task automatic t_enable();
    restart(0, 1, 5, 40);
    push(500, "R7 before disable");
    push(600, "R7 before disable");
    push(700, "R7 before disable");
    set_cfg(1'b0, 0, 1, 5, 40);
    push(900, "R7 ignored while off");
    push(1100, "R7 ignored while off");
    set_cfg(1'b1, 0, 1, 5, 40);
    push(1300, "R7 history cleared");
  endtask

  task automatic t_zero_taps();
    restart(1, 2, 0, 40);
    push(12345, "R8 zero taps");
    push(-12345, "R8 zero taps");
  endtask

  task automatic t_top_addr();
    wr_addr(335);
    wr_coef(32'h400000);
    wr_coef(32'h3FFFFF);                   // R2: dropped, beyond the memory
    restart(0, 1, 2, 335);
    push(2222, "R2 top address");
    push(-3333, "R2 read past end is zero");
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    for (int i = 0; i < 336; i++) coef_m[i] = 0;
    ptr_m = 0; phase_m = 0;
    cur_en = 1'b0; cur_mode = 0; cur_dec = 1; cur_taps = 0; cur_base = 0;
    rst_n = 1'b0;
    cfg_wr_en = 1'b0; cfg_wr_sel = 1'b0; cfg_wr_data = 32'h0;
    stage_ctrl = 32'h0; stage_base = 9'h0;
    in_valid = 1'b0; in_data = 24'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_identity();
    t_fir_offset();
    t_decim();
    t_round();
    t_sat();
    t_enable();
    t_zero_taps();
    t_top_addr();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule